// File: doc/BRIEF.md
# Two-Stage Baud Rate Generator

This block derives two timing strobes from a system clock for a serial port. The first stage divides a selectable reference clock enable by a 16-bit generator divisor and produces a bit-sample tick. The second stage counts those sample ticks and produces a baud tick once every (divider + 1) sample ticks. The resulting baud rate is the reference rate divided by ((divider + 1) × generator divisor). For example, a generator divisor of 62 with a divider of 6 puts a 50 MHz-class reference near 115200 baud.

The two reference clocks are modelled as clock enables in the single system clock domain, and a select pin picks one of them. Both divisors are loaded through plain write strobes. The block accepts any generator divisor, and a divisor of zero parks the generator. Writes of a divider value below the minimum are dropped. Every accepted write restarts both counters, so a new rate begins from a clean phase. No data flows through the block, so it has no valid/ready interface: every pin is a plain control or status pin, and the tick outputs cannot be back-pressured.

Top module: `baud_gen_top`

## Requirements
- R1: After reset the generator divisor is 0 and the baud divider is 15. No tick is produced until the generator divisor is written.
- R2: While the generator divisor is 0, neither sample_tick nor baud_tick is ever asserted.
- R3: With generator divisor N (1 to 65535), sample_tick is a one-cycle pulse once per N enabled reference cycles. It goes high in the cycle after the clock edge that counts the N-th enabled cycle.
- R4: With divider D, baud_tick is a one-cycle pulse on every (D+1)-th sample_tick and is high only in a cycle where sample_tick is also high.
- R5: A divider write with a value below 4 is ignored. The previous divider is kept, and the counters continue without restarting.
- R6: Divider writes with values 4 to 255 are accepted and take effect on the next cycle.
- R7: Any generator write, and any accepted divider write, clears both counters and both ticks at that edge. The reference enable in the write cycle is not counted, so the next sample tick follows N further enabled cycles.
- R8: clk_sel = 0 selects ref_en_a and clk_sel = 1 selects ref_en_b. Only the selected enable advances the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | Reference select: 0 = ref_en_a, 1 = ref_en_b |
| ref_en_a | input | 1 | Enable pulse of reference clock A |
| ref_en_b | input | 1 | Enable pulse of reference clock B |
| gen_wr | input | 1 | Write strobe for the generator divisor |
| gen_wdata | input | 16 | Generator divisor value |
| div_wr | input | 1 | Write strobe for the baud divider |
| div_wdata | input | 8 | Baud divider value |
| sample_tick | output | 1 | One-cycle bit-sample strobe |
| baud_tick | output | 1 | One-cycle baud strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit generator, an 8-bit divider, a minimum divider of 4 and a reset divider of 15. These values bring within reach both generator extremes, a divisor of 1 (a tick on every enabled cycle) and 65535 (one tick in a full 65535-cycle window). They also cover the divider floor of 4 and a rejected write of 3 just below it. A behavioural model compares both strobes on every cycle, including the cases where a restart lands mid-count and where the slower reference B is selected while reference A keeps pulsing.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } ref_src_e;
endpackage

// File: rtl/bg_src_sel.sv
module bg_src_sel
  import baudgen_pkg::*;
(
  input  logic sel,
  input  logic en_a,
  input  logic en_b,
  output logic en_out
);
  ref_src_e src;
  assign src = ref_src_e'(sel);

  always_comb begin
    unique case (src)
      SRC_A:   en_out = en_a;
      SRC_B:   en_out = en_b;
      default: en_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/bg_divisor_regs.sv
module bg_divisor_regs #(
  parameter int GEN_W   = 16,
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 4,
  parameter int DIV_RST = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_wr,
  input  logic [GEN_W-1:0] gen_wdata,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [GEN_W-1:0] gen_q,
  output logic [DIV_W-1:0] div_q,
  output logic             restart
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] RST_V = DIV_W'(DIV_RST);

  logic div_accept;
  assign div_accept = div_wr && (div_wdata >= MIN_V);
  assign restart    = gen_wr || div_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
      div_q <= RST_V;
    end else begin
      if (gen_wr)     gen_q <= gen_wdata;
      if (div_accept) div_q <= div_wdata;
    end
  end

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    div_q >= MIN_V); // R5
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr && div_wdata < MIN_V) |=> $stable(div_q)); // R5
  AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr && div_wdata >= MIN_V) |=> (div_q == $past(div_wdata))); // R6
endmodule

// File: rtl/bg_stage.sv
module bg_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         active,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         fire,
  output logic         tick_q
);
  logic [W-1:0] cnt;

  assign fire = active && step && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= fire;
      if (active && step) begin
        if (cnt == last) cnt <= '0;
        else             cnt <= cnt + W'(1);
      end
    end
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |=> !tick_q); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= last)); // R3
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !tick_q)); // R7
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top #(
  parameter int GEN_W   = 16,
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 4,
  parameter int DIV_RST = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_sel,
  input  logic             ref_en_a,
  input  logic             ref_en_b,
  input  logic             gen_wr,
  input  logic [GEN_W-1:0] gen_wdata,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             sample_tick,
  output logic             baud_tick
);
  logic [GEN_W-1:0] gen_q;
  logic [DIV_W-1:0] div_q;
  logic             restart;
  logic             ref_en;
  logic             gen_on;
  logic [GEN_W-1:0] gen_last;
  logic             sample_fire;
  logic             baud_fire;

  bg_src_sel u_sel (
    .sel    (clk_sel),
    .en_a   (ref_en_a),
    .en_b   (ref_en_b),
    .en_out (ref_en)
  );

  bg_divisor_regs #(
    .GEN_W(GEN_W), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_wr    (gen_wr),
    .gen_wdata (gen_wdata),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .gen_q     (gen_q),
    .div_q     (div_q),
    .restart   (restart)
  );

  assign gen_on   = (gen_q != '0);
  assign gen_last = gen_q - GEN_W'(1);

  bg_stage #(.W(GEN_W)) u_sample (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .active  (gen_on),
    .step    (ref_en),
    .last    (gen_last),
    .fire    (sample_fire),
    .tick_q  (sample_tick)
  );

  bg_stage #(.W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .active  (1'b1),
    .step    (sample_fire),
    .last    (div_q),
    .fire    (baud_fire),
    .tick_q  (baud_tick)
  );

  AST_BAUD_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> sample_tick); // R4
  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && gen_q > GEN_W'(1)) |=> !sample_tick); // R3
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sample_tick && !baud_tick)); // R7
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_on) |=> !baud_tick); // R2
endmodule

// File: tb/baud_gen_top_tb_top.sv
`timescale 1ns/1ps
module baud_gen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_sel = 1'b0;
  logic        ref_en_a = 1'b1;
  logic        ref_en_b = 1'b0;
  logic        gen_wr = 1'b0;
  logic [15:0] gen_wdata = '0;
  logic        div_wr = 1'b0;
  logic [7:0]  div_wdata = '0;
  logic        sample_tick;
  logic        baud_tick;

  always #4 clk = ~clk;

  baud_gen_top dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .ref_en_a(ref_en_a), .ref_en_b(ref_en_b),
    .gen_wr(gen_wr), .gen_wdata(gen_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata),
    .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit a_toggle = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_gen, m_div, m_cs, m_cb;
  bit m_st, m_bt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gen = 0; m_div = 15; m_cs = 0; m_cb = 0; m_st = 0; m_bt = 0;
    end else begin
      bit en, acc, fire;
      en  = clk_sel ? ref_en_b : ref_en_a;
      acc = div_wr && (int'(div_wdata) >= 4);
      if (gen_wr || acc) begin
        if (gen_wr) m_gen = int'(gen_wdata);
        if (acc)    m_div = int'(div_wdata);
        m_cs = 0; m_cb = 0; m_st = 0; m_bt = 0;
      end else begin
        fire = en && (m_gen != 0) && (m_cs == m_gen - 1);
        m_st = fire;
        m_bt = fire && (m_cb == m_div);
        if (en && m_gen != 0) m_cs = fire ? 0 : m_cs + 1;
        if (fire) m_cb = (m_cb == m_div) ? 0 : m_cb + 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (sample_tick !== m_st || baud_tick !== m_bt) begin
        fails++;
        $display("FAIL %s cycle compare: sample/baud actual %b%b expected %b%b",
                 cur_req, sample_tick, baud_tick, m_st, m_bt);
      end
    end
  end

  // enable patterns: reference B pulses every third cycle, A optionally toggles
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    ref_en_b <= (cyc % 3 == 0);
    if (a_toggle) ref_en_a <= ~ref_en_a;
  end

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write(bit g, int gv, bit d, int dv);
    @(negedge clk);
    gen_wr = g; gen_wdata = 16'(gv);
    div_wr = d; div_wdata = 8'(dv);
    @(posedge clk);
    @(negedge clk);
    gen_wr = 1'b0; div_wr = 1'b0;
  endtask

  task automatic count(int n, output int s, output int b);
    s = 0; b = 0;
    repeat (n) begin
      @(negedge clk);
      s += sample_tick;
      b += baud_tick;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset state, generator parked
    cur_req = "R1";
    count(50, s, b);
    check("R1", s, 0, "sample ticks after reset");
    check("R2", b, 0, "baud ticks with generator 0");

    // R1: reset divider 15 -> 16 samples per baud, gen 2
    write(1, 2, 0, 0);
    count(64, s, b);
    check("R1", s, 32, "sample ticks gen=2");
    check("R1", b, 2, "baud ticks with reset divider");

    // R3 / R4 / R6: gen 5, divider 4
    cur_req = "R3";
    write(1, 5, 1, 4);
    count(100, s, b);
    check("R3", s, 20, "sample ticks gen=5");
    check("R4", b, 4, "baud ticks div=4");

    // R5: rejected divider write keeps phase and value
    cur_req = "R5";
    write(0, 0, 1, 3);
    count(150, s, b);
    check("R5", b, 6, "baud ticks after rejected write");

    // R6: divider 255 accepted with gen 1
    cur_req = "R6";
    write(1, 1, 1, 255);
    count(256, s, b);
    check("R6", s, 256, "sample ticks gen=1");
    check("R6", b, 1, "baud ticks div=255");

    // R7: restart mid-count
    cur_req = "R7";
    write(1, 10, 1, 4);
    count(7, s, b);
    write(1, 10, 0, 0);
    count(9, s, b);
    check("R7", s, 0, "ticks before restarted period ends");
    count(1, s, b);
    check("R7", s, 1, "tick at end of restarted period");

    // R2: generator switched off mid-run
    cur_req = "R2";
    write(1, 0, 0, 0);
    count(40, s, b);
    check("R2", s + b, 0, "ticks while generator 0");

    // R8: select reference B while A toggles
    cur_req = "R8";
    clk_sel = 1'b1;
    a_toggle = 1;
    write(1, 3, 1, 4);
    count(450, s, b);
    check("R8", s, 50, "sample ticks from reference B");
    check("R8", b, 10, "baud ticks from reference B");
    clk_sel = 1'b0;
    a_toggle = 0;
    @(negedge clk);
    ref_en_a = 1'b1;

    // R3 boundary: largest generator divisor
    cur_req = "R3";
    write(1, 65535, 1, 4);
    count(65534, s, b);
    check("R3", s, 0, "no tick before 65535 cycles");
    count(1, s, b);
    check("R3", s, 1, "tick at 65535 cycles");

    finish_run();
  end
endmodule